// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K locations by 8 bits. A host request holds a direction flag, a 19-bit address and, for stores, one byte of data. The block turns each request into one memory cycle on the active-low chip-select, output-enable and write-enable strobes, and it counts clock cycles so that every nanosecond minimum of the memory is met. The clock period and the speed grade are parameters. The block rounds each timing minimum up to a whole number of cycles when it is elaborated.

The request side is a valid/ready stream. `req_ready` is high only while the controller is idle. A request is taken on the clock edge where both `req_valid` and `req_ready` are high. The host must hold `req_valid` and its fields stable until that edge. The completion side is a one-cycle `rsp_valid` pulse and cannot be held back. The host must be able to take it in any cycle, and `rsp_rdata` carries the loaded byte for read cycles.

The memory data pins are modelled as a driven value, an output enable and a sampled input, ready for a tri-state pad. Stores always use the mode where output-enable stays high, so the memory never drives the bus while the controller does.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip-select, output-enable and write-enable are high (inactive), the data bus is not driven, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in the idle state, so `req_valid` asserted during a cycle starts nothing.
- R3: A read holds chip-select and output-enable low and write-enable high for exactly RD = ceil(T_RC / CLK_NS) cycles. T_RC is 55 ns for the fast grade and 70 ns for the slow grade, so the count is 6 at the fast grade with a 10 ns clock.
- R4: Read data is sampled from the bus on the last of the RD cycles. It is returned on `rsp_rdata` in the following cycle, with `rsp_valid` high.
- R5: A write holds chip-select and write-enable low for exactly WR cycles. WR is the largest of ceil(T_WP / CLK_NS), ceil(T_DW / CLK_NS) and ceil(T_WC / CLK_NS) - 1. T_WP is 40 or 50 ns, T_DW is 25 or 30 ns and T_WC is 55 or 70 ns, so the count is 5 at the fast grade with a 10 ns clock.
- R6: The controller drives the data bus in every cycle where write-enable is low, plus exactly one hold cycle after it. The driven byte is the request's write data and stays unchanged for that whole time.
- R7: After every memory cycle, chip-select is high for at least one clock cycle, and `rsp_valid` is raised in that cycle. A new cycle therefore starts no sooner than RD+2 or WR+2 cycles after the previous one started.
- R8: The address is stable for as long as chip-select is low and through the recovery cycle that follows.
- R9: Output-enable and write-enable are never low at the same time, and output-enable stays high for the whole of a write.
- R10: `rsp_valid` is a single-cycle pulse, issued exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Memory address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Loaded byte, valid with rsp_valid on reads |
| sram_addr | output | 19 | Address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Byte driven toward the data pins |
| sram_dq_oe | output | 1 | Enables the data pin drivers |
| sram_dq_in | input | 8 | Byte sampled from the data pins |

## Verification
The bench builds the block with a 10 ns clock and the fast grade. With those values, 55 ns rounds to 6 read cycles, and the write length comes from the cycle-time term (5 cycles) rather than the pulse-width term (4 cycles). A cycle count that is one too short therefore becomes visible. The bench's memory model returns a garbage byte until 55 ns have passed with both strobes low. It also measures the write pulse and the data stability in nanoseconds, so a rounding or sequencing error shows up as wrong data or a failed timing check. Requests are sent back to back with `req_valid` held high, as well as with idle gaps, and they cover both ends of the address range.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACC  = 2'd1,
    SEQ_REC  = 2'd2
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_write,
  input  logic cur_write,
  input  logic last,
  output logic idle,
  output logic capture,
  output logic cs_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe,
  output logic done
);
  seq_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cs_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          done <= 1'b0;
          if (start) begin
            state <= SEQ_ACC;
            cs_n  <= 1'b0;
            oe_n  <= start_write;
            we_n  <= !start_write;
            dq_oe <= start_write;
          end
        end
        SEQ_ACC: begin
          if (last) begin
            state <= SEQ_REC;
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            done  <= 1'b1;
          end
        end
        default: begin
          state <= SEQ_IDLE;
          dq_oe <= 1'b0;
          done  <= 1'b0;
        end
      endcase
    end
  end

  assign idle    = (state == SEQ_IDLE);
  assign capture = (state == SEQ_ACC) && last && !cur_write;

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  p_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
endmodule

// File: rtl/sram_ctl_path.sv
module sram_ctl_path #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              capture,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (start) begin
        cur_write <= in_write;
        cur_addr  <= in_addr;
        cur_wdata <= in_wdata;
      end
      if (capture) rdata <= bus_in;
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter bit FAST_GRADE = 1'b1,
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int T_CYC_NS = FAST_GRADE ? 55 : 70;
  localparam int T_WP_NS  = FAST_GRADE ? 40 : 50;
  localparam int T_DW_NS  = FAST_GRADE ? 25 : 30;
  localparam int RD_CYC   = ceil_div(T_CYC_NS, CLK_NS);
  localparam int WP_CYC   = max2(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_DW_NS, CLK_NS));
  localparam int WR_CYC   = max2(max2(WP_CYC, ceil_div(T_CYC_NS, CLK_NS) - 1), 1);
  localparam int CNT_W    = $clog2(max2(RD_CYC, WR_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

  logic start, last, idle, capture, cur_write;

  assign start     = req_valid && idle;
  assign req_ready = idle;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start),
    .load_val(req_write ? WR_LOAD : RD_LOAD), .at_zero(last)
  );

  sram_ctl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write),
    .cur_write(cur_write), .last(last), .idle(idle), .capture(capture),
    .cs_n(sram_cs_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .dq_oe(sram_dq_oe), .done(rsp_valid)
  );

  sram_ctl_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rst_n(rst_n), .start(start), .capture(capture),
    .in_write(req_write), .in_addr(req_addr), .in_wdata(req_wdata),
    .bus_in(sram_dq_in), .cur_write(cur_write), .cur_addr(sram_addr),
    .cur_wdata(sram_dq_out), .rdata(rsp_rdata)
  );

  // Strobe-length monitors for the assertions below
  logic [CNT_W:0] oe_low_cnt, we_low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_low_cnt <= '0;
      we_low_cnt <= '0;
    end else begin
      oe_low_cnt <= sram_oe_n ? '0 : oe_low_cnt + 1'b1;
      we_low_cnt <= sram_we_n ? '0 : we_low_cnt + 1'b1;
    end
  end

  p_rd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_low_cnt == (CNT_W+1)'(RD_CYC)));
  p_wr_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt == (CNT_W+1)'(WR_CYC)));
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!sram_cs_n && !req_ready));
  p_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(sram_addr));
endmodule

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int T_RC = 55, T_WP = 40, T_DW = 25;
  localparam int RD_N = 6, WR_N = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, cs_n, oe_n, we_n, dq_oe;
  logic [7:0] rsp_rdata, dq_out;
  logic [7:0] dq_in = 8'hEE;
  logic [18:0] sram_addr;

  int n_checks = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(cs_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] init_pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // ---------------- behavioural memory device ----------------
  logic [7:0] dev_mem [int];
  int sel_cnt = 0, we_cnt = 0;
  bit data_stable;
  logic [7:0] we_data;
  logic prev_we_n = 1'b1;

  always @(negedge clk) begin
    if (!cs_n && !oe_n && we_n) sel_cnt++; else sel_cnt = 0;
    if (sel_cnt > 0 && (sel_cnt * CLK_NS - CLK_NS/2) >= T_RC)
      dq_in <= dev_mem.exists(int'(sram_addr)) ? dev_mem[int'(sram_addr)] : init_pat(sram_addr);
    else
      dq_in <= 8'hEE;
    if (rst_n) begin
      if (!we_n) begin
        if (prev_we_n) begin we_cnt = 0; data_stable = 1'b1; we_data = dq_out; end
        we_cnt++;
        if (!dq_oe || dq_out !== we_data) data_stable = 1'b0;
        chk("R9 oe high during write", oe_n, 1'b1);
      end else if (!prev_we_n) begin
        chk("R5 write pulse ns >= T_WP", (we_cnt * CLK_NS >= T_WP), 1'b1);
        chk("R6 data stable for setup", (data_stable && we_cnt * CLK_NS >= T_DW), 1'b1);
        chk("R6 hold cycle drives", dq_oe, 1'b1);
        chk("R6 hold data", dq_out, we_data);
        dev_mem[int'(sram_addr)] = we_data;
      end
    end
    prev_we_n = we_n;
  end

  // ---------------- cycle reference model ----------------
  logic [7:0] ref_mem [int];
  int ph = 0, left = 0;
  bit m_wr, accepted;
  logic [18:0] m_addr;
  logic [7:0] m_wdata, m_exp;

  always @(posedge clk) begin
    accepted = 1'b0;
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req_valid) begin
           ph = 1; m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata;
           left = req_write ? WR_N : RD_N; accepted = 1'b1;
           if (req_write) ref_mem[int'(req_addr)] = req_wdata;
           else m_exp = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : init_pat(req_addr);
         end
      1: begin left--; if (left == 0) ph = 2; end
      default: ph = 0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ready only when idle", req_ready, ph == 0);
      chk("R7 cs low only inside cycle", cs_n, ph != 1);
      chk("R3 oe strobe", oe_n, !(ph == 1 && !m_wr));
      chk("R5 we strobe", we_n, !(ph == 1 && m_wr));
      chk("R6 bus drive window", dq_oe, (ph == 1 || ph == 2) && m_wr);
      chk("R10 done pulse", rsp_valid, ph == 2);
      if (ph != 0) chk("R8 address held", sram_addr, m_addr);
      if (ph != 0 && m_wr) chk("R6 write data", dq_out, m_wdata);
      if (ph == 2 && !m_wr) chk("R4 read data", rsp_rdata, m_exp);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit w, input logic [18:0] a, input logic [7:0] d, input int gap);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!accepted);
    if (gap > 0) begin
      req_valid = 1'b0; req_addr = 19'h2AAAA; req_wdata = 8'h00;
      repeat (gap) @(negedge clk);
    end
  endtask

  int cyc = 0;
  bit timed_out = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !timed_out) begin
      timed_out = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1'b1);
    chk("R1 oe_n", oe_n, 1'b1);
    chk("R1 we_n", we_n, 1'b1);
    chk("R1 dq_oe", dq_oe, 1'b0);
    chk("R1 rsp_valid", rsp_valid, 1'b0);
    chk("R1 ready", req_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // single write then read with gaps
    send(1'b1, 19'h00000, 8'hA5, 3);
    send(1'b0, 19'h00000, 8'h00, 3);
    // read of never-written location (R4)
    send(1'b0, 19'h12345, 8'h00, 2);
    // top of address range
    send(1'b1, 19'h7FFFF, 8'h3C, 0);
    send(1'b0, 19'h7FFFF, 8'h00, 0);
    // back-to-back with valid held (R2, R7)
    for (int i = 0; i < 12; i++)
      send(1'b1, 19'(i * 4099), 8'(i * 37 + 1), 0);
    for (int i = 0; i < 12; i++)
      send(1'b0, 19'(i * 4099), 8'h00, (i % 3));
    // overwrite and alternate directions
    send(1'b1, 19'h00010, 8'hFF, 0);
    send(1'b1, 19'h00010, 8'h00, 1);
    send(1'b0, 19'h00010, 8'h00, 0);
    send(1'b1, 19'h55555, 8'h81, 0);
    send(1'b0, 19'h55555, 8'h00, 0);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 no stray done when idle", rsp_valid, 1'b0);
    chk("R1 idle strobes restored", {cs_n, oe_n, we_n, dq_oe}, 4'b1110);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule